// File: doc/BRIEF.md
# Timer tick source selector and prescaler

This block decides when a timer/counter advances. Each system clock it looks at a 3-bit select code. It then produces a one-clock count-enable strobe, `tick_o`, when the chosen source has a tick. The sources are:

- nothing at all (the timer is stopped);
- every system clock;
- a power-of-two division of the clock, taken from a free-running 10-bit divider;
- a falling or rising edge of an asynchronous external pin.

The pin is synchronised and edge-detected inside the block. A synchronous clear input restarts the divider, so a divided interval can be started from a known point. The output is registered, so a new code takes effect on the next clock edge.

The parameter `WIDE_TABLE` selects the decode table. With 0, codes 2 to 5 divide by 8, 64, 256 and 1024, and codes 6 and 7 count external edges. With 1, codes 2 to 7 divide by 8, 32, 64, 128, 256 and 1024, and there is no external source.

Top module: `tick_sel_prescaler`

## Requirements
- R1: With select code 000, `tick_o` stays low on the clock after every edge at which that code is sampled.
- R2: With select code 001, `tick_o` is high on the clock after every edge at which that code is sampled.
- R3: With `WIDE_TABLE`=0 and a divide code N (010=8, 011=64, 100=256, 101=1024), the strobe rises on the N-th edge after a clear, then once every N edges. "After a clear" means after the edge at which `psc_clr_i` was sampled high, or after reset release.
- R4: With `WIDE_TABLE`=0 and code 110, each falling edge of `ext_i` makes `tick_o` high for exactly one clock. That clock begins at the third rising clock edge after the pin changes, provided the pin is stable around each edge.
- R5: With `WIDE_TABLE`=0 and code 111, each rising edge of `ext_i` makes `tick_o` high for one clock, with the same three-edge lag as R4.
- R6: With `WIDE_TABLE`=1, codes 010 to 111 divide by 8, 32, 64, 128, 256 and 1024, with the phase rule of R3. Code 000 and code 001 behave as in R1 and R2.
- R7: While the code is held at any value other than 001, `tick_o` is never high on two consecutive clocks.
- R8: An edge at which `psc_clr_i` is high produces no divided strobe, and it resets the divider to zero.
- R9: A change of the select code governs `tick_o` from the first edge at which the new code is sampled. The old code produces no strobe after that edge.
- R10: In every code other than the two external-edge codes, `ext_i` has no effect on `tick_o`.
- R11: While `rst_ni` is low, `tick_o` is low. The divider and the synchroniser are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psc_clr_i | input | 1 | Synchronous divider clear |
| sel_i | input | 3 | Tick source select code |
| ext_i | input | 1 | Asynchronous external count pin |
| tick_o | output | 1 | One-clock count-enable strobe |

## Verification
The hardest situations to reach are the ones where the divider phase matters. A strobe by 1024 appears only after a long run, and a clear issued mid-interval must push the next strobe out by a full period. The stimulus therefore clears the divider, then holds each divide code for more than one full period. It issues a second clear in the middle of an interval and expects silence for the whole following period. The external pin keeps toggling through the divided and stopped phases, so that any leak of the pin into those codes shows up at the output.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [2:0] {SRC_OFF, SRC_CLK, SRC_DIV, SRC_FALL, SRC_RISE} src_e;

  typedef struct packed {
    src_e       src;
    logic [3:0] shift;  // log2 of the division ratio
  } tick_sel_t;

  function automatic tick_sel_t decode_sel(input logic [2:0] code, input logic wide);
    tick_sel_t d;
    d.src   = SRC_DIV;
    d.shift = 4'd0;
    unique case (code)
      3'd0: d.src = SRC_OFF;
      3'd1: d.src = SRC_CLK;
      3'd2: d.shift = 4'd3;
      3'd3: d.shift = wide ? 4'd5 : 4'd6;
      3'd4: d.shift = wide ? 4'd6 : 4'd8;
      3'd5: d.shift = wide ? 4'd7 : 4'd10;
      3'd6: if (wide) d.shift = 4'd8;  else d.src = SRC_FALL;
      3'd7: if (wide) d.shift = 4'd10; else d.src = SRC_RISE;
      default: d.src = SRC_OFF;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/prescale_div.sv
module prescale_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [DIV_W:1]   tap_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // tap k is high in the last cycle of each 2^k window
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign tap_o[k] = &cnt_q[k-1:0];
  end

  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;  // [0],[1] synchroniser, [2] history

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], ext_i};
  end

  assign rise_o =  sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] &  sh_q[2];

  p_fall_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_sel_prescaler.sv
module tick_sel_prescaler
  import tick_pkg::*;
#(
  parameter bit WIDE_TABLE = 1'b0,
  parameter int DIV_W      = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       psc_clr_i,
  input  logic [2:0] sel_i,
  input  logic       ext_i,
  output logic       tick_o
);
  logic [DIV_W:1] tap;
  logic           ext_rise, ext_fall;
  tick_sel_t      dec;
  logic           tick_d;

  prescale_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (psc_clr_i),
    .tap_o (tap)
  );

  ext_edge_sync u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_i),
    .rise_o(ext_rise),
    .fall_o(ext_fall)
  );

  always_comb begin
    dec    = decode_sel(sel_i, WIDE_TABLE);
    tick_d = 1'b0;
    unique case (dec.src)
      SRC_OFF:  tick_d = 1'b0;
      SRC_CLK:  tick_d = 1'b1;
      SRC_FALL: tick_d = ext_fall;
      SRC_RISE: tick_d = ext_rise;
      SRC_DIV: begin
        for (int k = 1; k <= DIV_W; k++)
          if (int'(dec.shift) == k) tick_d = tap[k] & ~psc_clr_i;
      end
      default:  tick_d = 1'b0;
    endcase
  end

  // registered select keeps switches glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= tick_d;
  end

  p_stop_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> !tick_o);
  p_pass_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |=> tick_o);
  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != 3'd1 && $stable(sel_i)) |=> !tick_o);
  p_clr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_clr_i && sel_i >= 3'd2 && (WIDE_TABLE || sel_i <= 3'd5)) |=> !tick_o);
endmodule

// File: tb/tick_sel_prescaler_tb_top.sv
module tick_sel_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       psc_clr = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       ext = 1'b0;
  logic       tick_s, tick_x;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  tick_sel_prescaler #(.WIDE_TABLE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .psc_clr_i(psc_clr),
    .sel_i(sel), .ext_i(ext), .tick_o(tick_s));

  tick_sel_prescaler #(.WIDE_TABLE(1'b1)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_ni), .psc_clr_i(psc_clr),
    .sel_i(sel), .ext_i(ext), .tick_o(tick_x));

  typedef struct {
    logic  exp_s;
    logic  exp_x;
    string req_s;
    string req_x;
  } item_t;
  item_t q[$];

  // bench reference state, from the requirements
  int unsigned b_cnt = 0;
  logic e1 = 1'b0, e2 = 1'b0, e3 = 1'b0;

  function automatic int shift_of(input logic [2:0] s, input bit wide);
    case (s)
      3'd2: return 3;
      3'd3: return wide ? 5 : 6;
      3'd4: return wide ? 6 : 8;
      3'd5: return wide ? 7 : 10;
      3'd6: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic expect_tick(input logic [2:0] s, input bit wide, input logic c);
    int unsigned m;
    if (s == 3'd0) return 1'b0;
    if (s == 3'd1) return 1'b1;
    if (!wide && s == 3'd6) return ~e2 & e3;
    if (!wide && s == 3'd7) return e2 & ~e3;
    m = (32'd1 << shift_of(s, wide)) - 1;
    return !c && ((b_cnt & m) == m);
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string who);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: tick actual=%b expected=%b at %0t", req, who, act, exp, $time);
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic step(input logic [2:0] s, input logic e, input logic c, input string req);
    item_t it;
    sel = s; ext = e; psc_clr = c;
    it.exp_s = expect_tick(s, 1'b0, c);
    it.exp_x = expect_tick(s, 1'b1, c);
    it.req_s = req;
    it.req_x = (s >= 3'd2) ? "R6" : req;
    q.push_back(it);
    b_cnt = c ? 0 : ((b_cnt + 1) % 1024);
    e3 = e2; e2 = e1; e1 = e;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] s, input int n, input int tog, input string req);
    for (int i = 0; i < n; i++) begin
      logic ev;
      ev = ext;
      if (tog > 0 && (i % tog) == 0) ev = ~ext;
      step(s, ev, 1'b0, req);
    end
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(tick_s, it.exp_s, it.req_s, "std");
      check(tick_x, it.exp_x, it.req_x, "wide");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tick_s, 1'b0, "R11", "std");  // R11 reset value
    check(tick_x, 1'b0, "R11", "wide");
    rst_ni = 1'b1;
    // R11: divider starts from zero at release
    run(3'd2, 20, 0, "R11");
    run(3'd0, 40, 3, "R1");
    run(3'd1, 20, 4, "R2");
    run(3'd0, 5, 0, "R9");
    run(3'd1, 3, 0, "R9");
    run(3'd2, 3, 0, "R9");
    run(3'd1, 2, 0, "R9");
    step(3'd2, ext, 1'b1, "R8");
    run(3'd2, 40, 0, "R3");
    run(3'd3, 200, 7, "R3");
    run(3'd4, 520, 0, "R3");
    run(3'd5, 2100, 0, "R3");
    run(3'd3, 30, 0, "R3");
    step(3'd3, ext, 1'b1, "R8");  // clear mid-interval
    run(3'd3, 70, 0, "R8");
    run(3'd3, 100, 1, "R10");     // pin toggles every clock
    run(3'd4, 300, 2, "R10");
    run(3'd6, 120, 5, "R4");
    run(3'd6, 40, 2, "R4");
    run(3'd7, 120, 5, "R5");
    run(3'd7, 40, 2, "R5");
    run(3'd7, 600, 0, "R7");
    run(3'd6, 1100, 3, "R7");
    run(3'd0, 3, 0, "R9");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule